// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block is a programmable down-counting timer meant to produce the periodic system tick of a processor subsystem. A power-of-two prescaler divides the core clock. Each prescaled tick moves a 16-bit counter one step down. When a tick arrives while the counter is already at zero, an interrupt flag is set. The counter then either restarts from the modulus value, for drift-free periodic operation, or wraps to 0xFFFF, for one-shot or free-running use. The interrupt request pin is raised while the flag is set and interrupts are enabled.

Software reaches the timer through a plain 16-bit register port with single-cycle writes and combinational reads. There are three registers: control/status at address 0, modulus at address 1 and the live counter at address 2. Address 3 reads as zero. This port carries register accesses and not a data stream, so it has no valid/ready handshake. A write is taken on the rising clock edge while `reg_wr` is high, and it is never back-pressured.

The usual setup sequence has three writes. First the control register is written with the run bit clear. Then the modulus is written. Then the control register is written again with the run bit set. With reload on, one period lasts (modulus + 1) × 2^prescale clocks. Software can read the time elapsed in the current period at any moment as modulus minus counter.

Top module: `tick_timer`

## Requirements
- R1: After reset, control reads 0x0000, modulus and counter read 0xFFFF, and `irq` is low.
- R2: While the run bit (control bit 0) is 0, the counter reads the modulus value and the prescaler is held cleared. This still holds right after a modulus write. Writes to address 2 have no effect.
- R3: While running, the counter decrements once every 2^P clocks, where P is control bits 11:8. The first decrement comes 2^P clocks after the write that sets the run bit.
- R4: A tick at count 0 with reload (control bit 1) set sets the flag (control bit 2) and loads the counter from the modulus.
- R5: A tick at count 0 with reload clear sets the flag and wraps the counter to 0xFFFF.
- R6: `irq` is high exactly when the flag and the interrupt-enable bit (control bit 3) are both 1.
- R7: A control write with bit 2 = 1 clears the flag and does not disturb the count. A control write with bit 2 = 0 leaves the flag unchanged.
- R8: With overwrite (control bit 4) set, a modulus write loads the counter on the same edge and restarts the prescaler.
- R9: With overwrite clear, a modulus write leaves the running count alone, and the new value is used at the next reload.
- R10: If an expiry and a flag-clearing write land on the same edge, the flag ends up set.
- R11: Control reads back run, reload, flag, enable and overwrite at bits 0..4, two stored low-power bits at 5 and 6, and the prescale field at 11:8. All other bits read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 modulus, 2 counter |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
The bench times the first tick after enabling at several prescale settings. An off-by-one prescaler would move every count by a whole step. It lands a flag-clearing write on the exact expiry edge; a design that lets the clear win would lose a tick interrupt. It checks that a flag clear leaves the count alone and that a modulus write with overwrite clear waits for the next reload, so a design that restarts the count on either write would show up as period drift. It also checks that an overwrite write restarts the prescaler phase, and that a non-reload expiry wraps to 0xFFFF rather than to the modulus.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int B_RUN   = 0;
  localparam int B_RLD   = 1;
  localparam int B_FLAG  = 2;
  localparam int B_IE    = 3;
  localparam int B_OVW   = 4;
  localparam int B_LP0   = 5;
  localparam int B_LP1   = 6;
  localparam int PRE_LSB = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MOD  = 2'd1,
    A_CNT  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [PSEL_W-1:0] sel,
  output logic              tick
);
  localparam int DIV_W = (1 << PSEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // mask has the low 'sel' bits set: tick when those bits are all ones
  genvar g;
  generate
    for (g = 0; g < DIV_W; g++) begin : g_mask
      assign mask[g] = (PSEL_W'(g) < sel);
    end
  endgenerate

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (!run || restart) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             reload,
  input  logic             ovw,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] mod_q,
  output logic             expire
);
  logic force_load;
  assign force_load = mod_wr && ovw;
  assign expire     = run && tick && (cnt_q == '0) && !force_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mod_q <= '1;
    else if (mod_wr) mod_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (!run) begin
      cnt_q <= mod_wr ? wdata : mod_q;
    end else if (force_load) begin
      cnt_q <= wdata;
    end else if (tick) begin
      if (cnt_q == '0) cnt_q <= reload ? mod_q : '1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              run,
  output logic              reload,
  output logic              flag,
  output logic              ie,
  output logic              ovw,
  output logic [1:0]        lp,
  output logic [PSEL_W-1:0] psel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      reload <= 1'b0;
      ie     <= 1'b0;
      ovw    <= 1'b0;
      lp     <= '0;
      psel   <= '0;
    end else if (wr) begin
      run    <= wdata[B_RUN];
      reload <= wdata[B_RLD];
      ie     <= wdata[B_IE];
      ovw    <= wdata[B_OVW];
      lp     <= {wdata[B_LP1], wdata[B_LP0]};
      psel   <= wdata[PRE_LSB +: PSEL_W];
    end
  end

  // a new expiry outranks a clear landing on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag <= 1'b0;
    else if (expire)                flag <= 1'b1;
    else if (wr && wdata[B_FLAG])   flag <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import pit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic              ctrl_wr, mod_wr;
  logic              run, reload, flag, ie, ovw, tick, expire;
  logic [1:0]        lp;
  logic [PSEL_W-1:0] psel;
  logic [CNT_W-1:0]  cnt_q, mod_q;
  logic [DATA_W-1:0] ctrl_rd;

  assign ctrl_wr = reg_wr && (reg_addr_e'(reg_addr) == A_CTRL);
  assign mod_wr  = reg_wr && (reg_addr_e'(reg_addr) == A_MOD);

  pit_ctrl #(.DATA_W(DATA_W), .PSEL_W(PSEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(reg_wdata),
    .expire(expire), .run(run), .reload(reload), .flag(flag),
    .ie(ie), .ovw(ovw), .lp(lp), .psel(psel)
  );

  pit_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run),
    .restart(mod_wr && ovw), .sel(psel), .tick(tick)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .reload(reload), .ovw(ovw), .mod_wr(mod_wr),
    .wdata(reg_wdata[CNT_W-1:0]), .cnt_q(cnt_q), .mod_q(mod_q),
    .expire(expire)
  );

  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[B_RUN]               = run;
    ctrl_rd[B_RLD]               = reload;
    ctrl_rd[B_FLAG]              = flag;
    ctrl_rd[B_IE]                = ie;
    ctrl_rd[B_OVW]               = ovw;
    ctrl_rd[B_LP0]               = lp[0];
    ctrl_rd[B_LP1]               = lp[1];
    ctrl_rd[PRE_LSB +: PSEL_W]   = psel;
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = ctrl_rd;
      A_MOD:   reg_rdata = DATA_W'(mod_q);
      A_CNT:   reg_rdata = DATA_W'(cnt_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag && ie;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              reload,
  input logic              flag,
  input logic              ie,
  input logic              ovw,
  input logic              tick,
  input logic              expire,
  input logic              ctrl_wr,
  input logic              mod_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  mod_q,
  input logic              irq
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !mod_wr) |=> (cnt_q == $past(mod_q)));                       // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q != '0 && !mod_wr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q == '0 && reload && !mod_wr) |=> (cnt_q == $past(mod_q) && flag)); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q == '0 && !reload && !mod_wr) |=> (cnt_q == '1 && flag)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));                                                // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[2] && !expire) |=> !flag);                      // R7
  AST_OVW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_wr && ovw) |=> (cnt_q == $past(reg_wdata[CNT_W-1:0])));          // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);                                                     // R10
endmodule

bind tick_timer pit_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .reload(reload), .flag(flag),
  .ie(ie), .ovw(ovw), .tick(tick), .expire(expire), .ctrl_wr(ctrl_wr),
  .mod_wr(mod_wr), .reg_wdata(reg_wdata), .cnt_q(cnt_q), .mod_q(mod_q),
  .irq(irq)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {prescale, modulus, wait clocks, expected count}
  localparam logic [15:0] VEC [0:3][0:3] = '{
    '{16'd0, 16'd100, 16'd10, 16'd90},
    '{16'd1, 16'd50,  16'd9,  16'd46},
    '{16'd2, 16'd20,  16'd17, 16'd16},
    '{16'd3, 16'd5,   16'd40, 16'd0}
  };

  function automatic logic [15:0] ctl(input bit run, input bit rld, input bit clr,
                                      input bit ie, input bit ovw, input logic [3:0] p);
    return {4'b0, p, 3'b0, ovw, ie, clr, rld, run};
  endfunction

  // called at a negedge; the write lands on the next posedge, returns at the negedge after
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    waitn(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 mod", v, 16'hFFFF);
    rd(2'd2, v); chk("R1 cnt", v, 16'hFFFF);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // table: prescaled countdown after enabling (R2, R3)
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, ctl(0, 1, 1, 0, 0, VEC[i][0][3:0]));
      wr(2'd1, VEC[i][1]);
      rd(2'd2, v); chk("R2 stopped cnt follows mod", v, VEC[i][1]);
      wr(2'd0, ctl(1, 1, 1, 0, 0, VEC[i][0][3:0]));
      waitn(int'(VEC[i][2]));
      rd(2'd2, v); chk("R3 prescaled count", v, VEC[i][3]);
      rd(2'd0, v); chk("R3 no flag yet", {15'b0, v[2]}, 16'h0);
    end

    // R4 reload, R6 irq
    wr(2'd0, ctl(0, 1, 1, 1, 0, 4'd0));
    wr(2'd1, 16'd3);
    wr(2'd0, ctl(1, 1, 1, 1, 0, 4'd0));
    waitn(3);
    rd(2'd2, v); chk("R4 at zero", v, 16'd0);
    waitn(1);
    rd(2'd2, v); chk("R4 reload", v, 16'd3);
    rd(2'd0, v); chk("R4 flag set", {15'b0, v[2]}, 16'h1);
    chk("R6 irq high", {15'b0, irq}, 16'h1);
    // R7 clear without disturbing count
    wr(2'd0, ctl(1, 1, 1, 1, 0, 4'd0));
    rd(2'd2, v); chk("R7 count undisturbed", v, 16'd2);
    rd(2'd0, v); chk("R7 flag cleared", {15'b0, v[2]}, 16'h0);
    chk("R6 irq low", {15'b0, irq}, 16'h0);
    waitn(3);
    rd(2'd0, v); chk("R4 second expiry", {15'b0, v[2]}, 16'h1);
    wr(2'd0, ctl(1, 1, 0, 1, 0, 4'd0));
    rd(2'd0, v); chk("R7 write-0 keeps flag", {15'b0, v[2]}, 16'h1);
    // R10 clear on the expiry edge
    waitn(2);
    wr(2'd0, ctl(1, 1, 1, 1, 0, 4'd0));
    rd(2'd0, v); chk("R10 set wins", {15'b0, v[2]}, 16'h1);
    rd(2'd2, v); chk("R10 reloaded", v, 16'd3);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 4'd0));
    chk("R6 irq off when disabled", {15'b0, irq}, 16'h0);

    // R5 wrap without reload
    wr(2'd0, ctl(0, 0, 1, 0, 0, 4'd0));
    wr(2'd1, 16'd2);
    wr(2'd0, ctl(1, 0, 1, 0, 0, 4'd0));
    waitn(3);
    rd(2'd2, v); chk("R5 wrap", v, 16'hFFFF);
    rd(2'd0, v); chk("R5 flag", {15'b0, v[2]}, 16'h1);
    waitn(1);
    rd(2'd2, v); chk("R5 after wrap", v, 16'hFFFE);

    // R8 overwrite loads now and restarts prescaler
    wr(2'd0, ctl(1, 1, 1, 0, 1, 4'd2));
    waitn(2);
    wr(2'd1, 16'd1000);
    rd(2'd2, v); chk("R8 immediate load", v, 16'd1000);
    waitn(3);
    rd(2'd2, v); chk("R8 prescaler phase", v, 16'd1000);
    waitn(1);
    rd(2'd2, v); chk("R8 first tick", v, 16'd999);

    // R9 deferred modulus
    wr(2'd0, ctl(0, 1, 1, 0, 0, 4'd0));
    wr(2'd1, 16'd5);
    wr(2'd0, ctl(1, 1, 1, 0, 0, 4'd0));
    waitn(1);
    wr(2'd1, 16'd2);
    rd(2'd2, v); chk("R9 count continues", v, 16'd3);
    rd(2'd1, v); chk("R9 mod stored", v, 16'd2);
    waitn(4);
    rd(2'd2, v); chk("R9 new mod at reload", v, 16'd2);

    // R11 readback layout, R2 counter writes ignored
    wr(2'd0, 16'hFFFE);
    rd(2'd0, v); chk("R11 ctrl readback", v, 16'h0F7A);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R2 counter write ignored", v, 16'd2);
    rd(2'd3, v); chk("R11 addr3 zero", v, 16'h0000);

    finish_run();
  end
endmodule